// File: doc/BRIEF.md
# Subaddress Data Buffer Pointer Manager

This block keeps the data-buffer pointers for a serial-bus remote terminal. It holds a table with one pointer and one control byte for each subaddress. A table entry is chosen by the transfer direction, by the subaddress and, optionally, by whether the message was broadcast. When a message begins, the block loads the selected pointer into a word cursor. It then presents one data-word address for each word strobe. When the message ends, it decides whether to write the pointer back and with what value.

Three buffering schemes can be chosen for each subaddress. Single-message mode reuses one fixed block. Double-buffer mode swaps between two 32-word halves after every valid receive. Circular mode walks through a naturally aligned ring of 128 to 8192 words. Each entry can also enable a per-message interrupt pulse, a ring-rollover interrupt pulse, and a rule that freezes a circular pointer after an invalid message. A host port reads and writes the table while no message is open.

Top module: `sa_ptr_mgr`

## Requirements
- R1: After reset, `busy`, `data_addr_vld`, `wb_vld`, `irq_msg` and `irq_roll` are low, and every table pointer and control byte reads back as 0.
- R2: The table index is {msg_bcst & ~msg_tr, msg_tr, msg_sa}. Host index 64+sa holds the broadcast receive entry, 32+sa the transmit entry and sa the receive entry. These three entries are independent. host_sel=0 selects the pointer and host_sel=1 selects the control byte (zero-extended on read).
- R3: While `busy` is high, a `word_strobe` gives `data_addr_vld` high in the same cycle, for at most `msg_wcnt` strobes (0 means 32). In single and double mode, word n has the address start pointer + n. Any further strobes give `data_addr_vld` low.
- R4: The control byte holds scheme in [1:0] (0 single, 1 double, 2 circular, 3 single), size in [4:2], per-message interrupt enable in [5], rollover interrupt enable in [6] and hold-on-invalid in [7]. In circular mode, the word after the last location of the ring goes to the ring's first location. Address bits at and above the ring size never change.
- R5: A size code n in 0..6 gives a ring of 128<<n words. Code 7 gives 8192 words.
- R6: In circular mode, the stored pointer becomes the location just after the last word accessed. In the cycle after `msg_end`, `wb_vld` pulses for one cycle with that value on `wb_ptr`.
- R7: If hold-on-invalid is set, an invalid circular message (`msg_ok` low) leaves the pointer unchanged and raises no `wb_vld`. If it is clear, an invalid message updates the pointer just as a valid one does.
- R8: In double mode on a receive or broadcast entry, a valid message writes back the start pointer with bit 5 inverted. An invalid message writes nothing.
- R9: A transmit entry set to double mode behaves as single mode and never writes back.
- R10: Single mode never changes the stored pointer.
- R11: If the per-message interrupt enable is set, `irq_msg` pulses for one cycle after every `msg_end`, whether the message was valid or not.
- R12: `irq_roll` pulses with `wb_vld` when a circular message that wrapped commits its pointer and the rollover interrupt enable is set.
- R13: While `busy` is high, host writes and new `msg_start` requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 pointer, 1 control byte |
| host_idx | input | IDX_W | Host table index |
| host_wdata | input | ADDR_W | Host write data |
| host_rdata | output | ADDR_W | Combinational read of the addressed entry |
| msg_start | input | 1 | Opens a message |
| msg_bcst | input | 1 | Message was broadcast |
| msg_tr | input | 1 | 1 transmit, 0 receive |
| msg_sa | input | SA_W | Subaddress |
| msg_wcnt | input | 5 | Word count, 0 means 32 |
| word_strobe | input | 1 | Requests the next data-word address |
| msg_end | input | 1 | Closes the message |
| msg_ok | input | 1 | Message was valid, sampled with msg_end |
| busy | output | 1 | A message is open |
| data_addr | output | ADDR_W | Current data-word address |
| data_addr_vld | output | 1 | data_addr belongs to this strobe |
| wb_vld | output | 1 | Pointer was written back |
| wb_ptr | output | ADDR_W | Value written back |
| irq_msg | output | 1 | Per-message interrupt pulse |
| irq_roll | output | 1 | Ring rollover interrupt pulse |

## Verification
The bench starts rings one or two words before their top at three sizes, including the largest and the clamped code 7. A design that masks the wrong number of bits runs out of the region or wraps to zero. It sends a word count of 0 and extra strobes, which catches a counter that treats 0 as empty or keeps issuing addresses. Invalid messages are run with hold-on-invalid set and clear, double mode is tried on both a receive entry and a transmit entry, and host writes and a second start are issued while a message is open. Each of these shows up as a wrong write-back or a wrong readback value.

// File: rtl/sa_ptr_pkg.sv
// Shared types for the subaddress pointer manager.
// Assumes ADDR_W >= 13 wherever the ring mask is widened.
package sa_ptr_pkg;

    typedef enum logic [1:0] {
        SCH_SINGLE = 2'd0,
        SCH_DOUBLE = 2'd1,
        SCH_CIRC   = 2'd2,
        SCH_RSVD   = 2'd3
    } scheme_e;

    // Per-subaddress control byte, msb first
    typedef struct packed {
        logic       hold_bad;
        logic       irq_roll_en;
        logic       irq_msg_en;
        logic [2:0] size;
        scheme_e    scheme;
    } sa_ctl_t;

    localparam int CTL_W     = 8;
    localparam int MASK_W    = 13;
    localparam int WCNT_W    = 5;
    localparam int DBL_BIT   = 5;

    // Low-bit mask of a ring: 128 << size words, code 7 clamps to 8192
    function automatic logic [MASK_W-1:0] ring_mask(input logic [2:0] size);
        logic [MASK_W:0] span;
        span = (MASK_W+1)'(128) << ((size == 3'd7) ? 3'd6 : size);
        return MASK_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/sa_lut.sv
// Pointer and control lookup table.
// One pointer and one control byte per entry. Host port and engine
// write-back port; the engine has priority (the top blocks host writes
// while a message is open, so they never collide in practice).
module sa_lut
    import sa_ptr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [ADDR_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] host_rdata,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [ADDR_W-1:0] eng_ptr,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [ADDR_W-1:0] lk_ptr,
    output sa_ctl_t           lk_ctl
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] ptr_mem [DEPTH];
    sa_ctl_t           ctl_mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        // Pointer storage: engine write-back first, then host
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_mem[e] <= '0;
            else if (eng_we && eng_idx == IDX_W'(e))
                ptr_mem[e] <= eng_ptr;
            else if (host_we && !host_sel && host_idx == IDX_W'(e))
                ptr_mem[e] <= host_wdata;
        end

        // Control storage: host only
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_mem[e] <= '0;
            else if (host_we && host_sel && host_idx == IDX_W'(e))
                ctl_mem[e] <= sa_ctl_t'(host_wdata[CTL_W-1:0]);
        end
    end

    // Read ports
    always_comb begin
        lk_ptr = ptr_mem[lk_idx];
        lk_ctl = ctl_mem[lk_idx];
        if (host_sel)
            host_rdata = {{(ADDR_W-CTL_W){1'b0}}, ctl_mem[host_idx]};
        else
            host_rdata = ptr_mem[host_idx];
    end

endmodule

// File: rtl/sa_cursor.sv
// Word cursor for one open message.
// Loads the start pointer, gives one address per accepted strobe, counts
// words up to the limit (0 means 32) and records a ring wrap.
module sa_cursor
    import sa_ptr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_ptr,
    input  logic              load_circ,
    input  logic [2:0]        load_size,
    input  logic [WCNT_W-1:0] load_wcnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_vld,
    output logic              wrapped
);
    localparam int CNT_W = WCNT_W + 1;

    logic [ADDR_W-1:0] cur;
    logic [CNT_W-1:0]  cnt, limit;
    logic              circ;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] nxt;
    logic              at_top;

    // Ring mask widened to address width
    always_comb begin
        mask = '0;
        mask[MASK_W-1:0] = ring_mask(load_size_q);
    end

    logic [2:0] load_size_q;

    // Next address and wrap detection
    always_comb begin
        at_top   = circ && ((cur & mask) == mask);
        nxt      = circ ? ((cur & ~mask) | ((cur + 1'b1) & mask)) : cur + 1'b1;
        addr     = cur;
        addr_vld = step && (cnt < limit);
    end

    // Cursor state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur         <= '0;
            cnt         <= '0;
            limit       <= '0;
            circ        <= 1'b0;
            load_size_q <= '0;
            wrapped     <= 1'b0;
        end else if (load) begin
            cur         <= load_ptr;
            cnt         <= '0;
            limit       <= (load_wcnt == '0) ? CNT_W'(32) : CNT_W'(load_wcnt);
            circ        <= load_circ;
            load_size_q <= load_size;
            wrapped     <= 1'b0;
        end else if (addr_vld) begin
            cur     <= nxt;
            cnt     <= cnt + 1'b1;
            wrapped <= wrapped | at_top;
        end
    end

endmodule

// File: rtl/sa_update.sv
// End-of-message decision: whether to write the pointer back, with what
// value, and which interrupts to raise. Purely combinational.
module sa_update
    import sa_ptr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  sa_ctl_t           ctl,
    input  logic              is_tx,
    input  logic              ok,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic              wrapped,
    output logic              do_write,
    output logic [ADDR_W-1:0] new_ptr,
    output logic              irq_msg_o,
    output logic              irq_roll_o
);
    // Scheme selection and commit rule
    always_comb begin
        do_write   = 1'b0;
        new_ptr    = start_ptr;
        irq_roll_o = 1'b0;
        irq_msg_o  = ctl.irq_msg_en;
        unique case (ctl.scheme)
            SCH_CIRC: begin
                do_write   = ok || !ctl.hold_bad;
                new_ptr    = end_ptr;
                irq_roll_o = do_write && wrapped && ctl.irq_roll_en;
            end
            SCH_DOUBLE: begin
                do_write = ok && !is_tx;
                new_ptr  = start_ptr ^ (ADDR_W'(1) << DBL_BIT);
            end
            default: begin
                do_write = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sa_ptr_mgr.sv
// Subaddress data-buffer pointer manager (top).
// Holds the pointer table, runs one message at a time, issues data-word
// addresses and writes pointers back at message end. Assumes msg_end
// arrives only while busy; strobes in the msg_end cycle are dropped.
module sa_ptr_mgr
    import sa_ptr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SA_W       = 5,
    parameter bit BCST_SPLIT = 1'b1,
    localparam int IDX_W     = SA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [ADDR_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] host_rdata,
    input  logic              msg_start,
    input  logic              msg_bcst,
    input  logic              msg_tr,
    input  logic [SA_W-1:0]   msg_sa,
    input  logic [4:0]        msg_wcnt,
    input  logic              word_strobe,
    input  logic              msg_end,
    input  logic              msg_ok,
    output logic              busy,
    output logic [ADDR_W-1:0] data_addr,
    output logic              data_addr_vld,
    output logic              wb_vld,
    output logic [ADDR_W-1:0] wb_ptr,
    output logic              irq_msg,
    output logic              irq_roll
);
    logic [IDX_W-1:0]  lk_idx, idx_q;
    logic [ADDR_W-1:0] lk_ptr, start_q, new_ptr;
    sa_ctl_t           lk_ctl, ctl_q;
    logic              tx_q, start_fire, end_fire, step;
    logic              do_write, upd_irq_msg, upd_irq_roll, wrapped;
    logic              bsel;

    // Table index from the message header
    always_comb begin
        bsel       = BCST_SPLIT && msg_bcst && !msg_tr;
        lk_idx     = {bsel, msg_tr, msg_sa};
        start_fire = msg_start && !busy;
        end_fire   = msg_end && busy;
        step       = word_strobe && busy && !msg_end;
    end

    sa_lut #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_wr && !busy),
        .host_sel   (host_sel),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_we     (end_fire && do_write),
        .eng_idx    (idx_q),
        .eng_ptr    (new_ptr),
        .lk_idx     (lk_idx),
        .lk_ptr     (lk_ptr),
        .lk_ctl     (lk_ctl)
    );

    sa_cursor #(.ADDR_W(ADDR_W)) u_cur (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_fire),
        .load_ptr  (lk_ptr),
        .load_circ (lk_ctl.scheme == SCH_CIRC),
        .load_size (lk_ctl.size),
        .load_wcnt (msg_wcnt),
        .step      (step),
        .addr      (data_addr),
        .addr_vld  (data_addr_vld),
        .wrapped   (wrapped)
    );

    sa_update #(.ADDR_W(ADDR_W)) u_upd (
        .ctl        (ctl_q),
        .is_tx      (tx_q),
        .ok         (msg_ok),
        .start_ptr  (start_q),
        .end_ptr    (data_addr),
        .wrapped    (wrapped),
        .do_write   (do_write),
        .new_ptr    (new_ptr),
        .irq_msg_o  (upd_irq_msg),
        .irq_roll_o (upd_irq_roll)
    );

    // Message context captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx_q   <= '0;
            start_q <= '0;
            ctl_q   <= '0;
            tx_q    <= 1'b0;
        end else if (start_fire) begin
            busy    <= 1'b1;
            idx_q   <= lk_idx;
            start_q <= lk_ptr;
            ctl_q   <= lk_ctl;
            tx_q    <= msg_tr;
        end else if (end_fire) begin
            busy    <= 1'b0;
        end
    end

    // Registered end-of-message results, one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld   <= 1'b0;
            wb_ptr   <= '0;
            irq_msg  <= 1'b0;
            irq_roll <= 1'b0;
        end else begin
            wb_vld   <= end_fire && do_write;
            wb_ptr   <= (end_fire && do_write) ? new_ptr : wb_ptr;
            irq_msg  <= end_fire && upd_irq_msg;
            irq_roll <= end_fire && upd_irq_roll;
        end
    end

endmodule

// File: rtl/sa_ptr_chk.sv
// Assertion checker for sa_ptr_mgr, attached by bind below.
module sa_ptr_chk
    import sa_ptr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              msg_end,
    input logic              data_addr_vld,
    input logic [ADDR_W-1:0] data_addr,
    input logic              wb_vld,
    input logic [ADDR_W-1:0] wb_ptr,
    input logic              irq_roll,
    input sa_ctl_t           ctl_q,
    input logic [ADDR_W-1:0] start_q,
    input logic              tx_q
);
    logic [ADDR_W-1:0] hi_mask;

    // Bits that a ring may not touch
    always_comb begin
        hi_mask = '1;
        hi_mask[MASK_W-1:0] = ~ring_mask(ctl_q.size);
    end

    a_r3_addr_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        data_addr_vld |-> busy);

    a_r4_ring_region: assert property (@(posedge clk) disable iff (!rst_n)
        (data_addr_vld && $past(data_addr_vld) && busy && $past(busy)
         && ctl_q.scheme == SCH_CIRC)
        |-> (((data_addr ^ $past(data_addr)) & hi_mask) == '0));

    a_r6_wb_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> $past(busy && msg_end));

    a_r8_double_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && $past(ctl_q.scheme) == SCH_DOUBLE)
        |-> (wb_ptr == ($past(start_q) ^ ADDR_W'(32))));

    a_r9_tx_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> !($past(tx_q) && $past(ctl_q.scheme) == SCH_DOUBLE));

    a_r10_single_static: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> ($past(ctl_q.scheme) == SCH_DOUBLE || $past(ctl_q.scheme) == SCH_CIRC));

    a_r12_roll_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
        irq_roll |-> wb_vld);

endmodule

bind sa_ptr_mgr sa_ptr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sa_ptr_mgr.sv
// Directed bench: one task per scenario, each checks its own results.
module tb_sa_ptr_mgr;
    localparam int AW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 0, host_sel = 0;
    logic [6:0] host_idx = '0;
    logic [AW-1:0] host_wdata = '0, host_rdata;
    logic msg_start = 0, msg_bcst = 0, msg_tr = 0, word_strobe = 0, msg_end = 0, msg_ok = 0;
    logic [4:0] msg_sa = '0, msg_wcnt = '0;
    logic busy, data_addr_vld, wb_vld, irq_msg, irq_roll;
    logic [AW-1:0] data_addr, wb_ptr;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    sa_ptr_mgr dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ix(input logic b, input logic t, input logic [4:0] s);
        return {b & ~t, t, s};
    endfunction

    task automatic quiet();
        host_wr = 0; msg_start = 0; word_strobe = 0; msg_end = 0;
    endtask

    task automatic hwrite(input logic sel, input logic [6:0] i, input logic [AW-1:0] d);
        @(negedge clk); quiet();
        host_wr = 1; host_sel = sel; host_idx = i; host_wdata = d;
    endtask

    task automatic hread(input string req, input logic sel, input logic [6:0] i, input logic [AW-1:0] exp);
        @(negedge clk); quiet();
        host_sel = sel; host_idx = i;
        #1 check(req, host_rdata, exp);
    endtask

    task automatic setup(input logic [6:0] i, input logic [AW-1:0] p, input logic [7:0] c);
        hwrite(0, i, p);
        hwrite(1, i, {8'h00, c});
    endtask

    task automatic start(input logic b, input logic t, input logic [4:0] s, input logic [4:0] w);
        @(negedge clk); quiet();
        msg_start = 1; msg_bcst = b; msg_tr = t; msg_sa = s; msg_wcnt = w;
    endtask

    task automatic word(input string req, input logic vld, input logic [AW-1:0] a);
        @(negedge clk); quiet();
        word_strobe = 1;
        #1;
        check(req, data_addr_vld, vld);
        if (vld) check(req, data_addr, a);
    endtask

    // Close the message and check registered results one edge later
    task automatic finish_msg(input string req, input logic ok, input logic ewb,
                              input logic [AW-1:0] eptr, input logic emsg, input logic eroll);
        @(negedge clk); quiet();
        msg_end = 1; msg_ok = ok;
        @(negedge clk); quiet();
        #1;
        check(req, wb_vld, ewb);
        if (ewb) check(req, wb_ptr, eptr);
        check(req, irq_msg, emsg);
        check(req, irq_roll, eroll);
        check(req, busy, 0);
    endtask

    task automatic t_reset();
        #1;
        check("R1 busy", busy, 0);
        check("R1 vld", data_addr_vld, 0);
        check("R1 wb", wb_vld, 0);
        check("R1 irq", {irq_msg, irq_roll}, 0);
        hread("R1 ptr", 0, 7'd5, 0);
        hread("R1 ctl", 1, 7'd70, 0);
    endtask

    task automatic t_single();
        setup(ix(0, 0, 3), 16'h0400, 8'h20);
        start(0, 0, 3, 3);
        word("R3 w0", 1, 16'h0400);
        word("R3 w1", 1, 16'h0401);
        word("R3 w2", 1, 16'h0402);
        word("R3 extra", 0, 0);
        finish_msg("R10 R11 single", 1, 0, 0, 1, 0);
        hread("R10 unchanged", 0, ix(0, 0, 3), 16'h0400);
    endtask

    task automatic t_count32();
        setup(ix(0, 0, 4), 16'h0800, 8'h00);
        start(0, 0, 4, 0);
        for (int n = 0; n < 32; n++) word("R3 wcnt0", 1, 16'h0800 + AW'(n));
        word("R3 past32", 0, 0);
        finish_msg("R11 no irq", 1, 0, 0, 0, 0);
    endtask

    task automatic t_ring128();
        setup(ix(0, 0, 5), 16'h127E, 8'h42);
        start(0, 0, 5, 4);
        word("R4 a", 1, 16'h127E);
        word("R4 b", 1, 16'h127F);
        word("R4 wrap", 1, 16'h1200);
        word("R4 d", 1, 16'h1201);
        finish_msg("R6 R12 ring128", 1, 1, 16'h1202, 0, 1);
        hread("R6 stored", 0, ix(0, 0, 5), 16'h1202);
    endtask

    task automatic t_ring_big();
        setup(ix(0, 1, 6), 16'h3FFF, 8'h1A);
        start(0, 1, 6, 2);
        word("R5 8k a", 1, 16'h3FFF);
        word("R5 8k wrap", 1, 16'h2000);
        finish_msg("R5 R12 no roll irq", 1, 1, 16'h2001, 0, 0);
        setup(ix(0, 1, 7), 16'h5FFF, 8'h1E);
        start(0, 1, 7, 2);
        word("R5 code7 a", 1, 16'h5FFF);
        word("R5 code7 wrap", 1, 16'h4000);
        finish_msg("R5 code7", 1, 1, 16'h4001, 0, 0);
        setup(ix(0, 0, 12), 16'h02FF, 8'h06);
        start(0, 0, 12, 2);
        word("R5 256 a", 1, 16'h02FF);
        word("R5 256 wrap", 1, 16'h0200);
        finish_msg("R5 256", 1, 1, 16'h0201, 0, 0);
    endtask

    task automatic t_invalid();
        setup(ix(0, 0, 8), 16'h0210, 8'h86);
        start(0, 0, 8, 2);
        word("R7 a", 1, 16'h0210);
        word("R7 b", 1, 16'h0211);
        finish_msg("R7 hold", 0, 0, 0, 0, 0);
        hread("R7 held", 0, ix(0, 0, 8), 16'h0210);
        hwrite(1, ix(0, 0, 8), 16'h0006);
        start(0, 0, 8, 2);
        word("R7 c", 1, 16'h0210);
        word("R7 d", 1, 16'h0211);
        finish_msg("R7 no hold", 0, 1, 16'h0212, 0, 0);
    endtask

    task automatic t_double();
        setup(ix(0, 0, 9), 16'h0C00, 8'h21);
        start(0, 0, 9, 2);
        word("R8 a", 1, 16'h0C00);
        word("R8 b", 1, 16'h0C01);
        finish_msg("R8 swap", 1, 1, 16'h0C20, 1, 0);
        start(0, 0, 9, 1);
        word("R8 other half", 1, 16'h0C20);
        finish_msg("R8 R11 invalid", 0, 0, 0, 1, 0);
        hread("R8 kept", 0, ix(0, 0, 9), 16'h0C20);
        setup(ix(0, 1, 9), 16'h0D00, 8'h01);
        start(0, 1, 9, 1);
        word("R9 tx", 1, 16'h0D00);
        finish_msg("R9 tx double", 1, 0, 0, 0, 0);
        hread("R9 kept", 0, ix(0, 1, 9), 16'h0D00);
    endtask

    task automatic t_bcst();
        setup(7'd73, 16'h0E00, 8'h00);
        start(1, 0, 9, 1);
        word("R2 bcst entry", 1, 16'h0E00);
        finish_msg("R2 bcst", 1, 0, 0, 0, 0);
        hread("R2 rx separate", 0, 7'd9, 16'h0C20);
        hread("R2 tx separate", 0, 7'd41, 16'h0D00);
    endtask

    task automatic t_busy();
        setup(ix(0, 0, 10), 16'h0A00, 8'h00);
        start(0, 0, 10, 3);
        hwrite(0, ix(0, 0, 10), 16'h1234);
        start(0, 0, 4, 3);
        word("R13 second start ignored", 1, 16'h0A00);
        finish_msg("R13 end", 1, 0, 0, 0, 0);
        hread("R13 host blocked", 0, ix(0, 0, 10), 16'h0A00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_count32();
        t_ring128();
        t_ring_big();
        t_invalid();
        t_double();
        t_bcst();
        t_busy();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule